// File: doc/BRIEF.md
# Wake Event Status and Enable Unit

This block collects eight single-cycle wake event pulses into a sticky status byte and pairs it with an enable byte of the same layout. Both bytes are held in a small byte-addressed register file on a simple host write/read bus. An arriving event always sets its status bit, whatever its enable bit holds. Software clears a status bit by writing a one to it.

Each status bit that is set and enabled raises the wake request. Sources 0 to 3 also raise a power-on control output. All eight sources feed a shared request that one routing input steers to either a system control interrupt output or a reset output. The bit positions, from bit 0 up, are: PME1, PME2, IR receiver 1, IR receiver 2, GPIO12, GPIO13, GPIO10, P12.

A power-up reset clears every register. A separate master reset clears only the upper half of the enable byte and leaves the rest of the state alone.

Top module: `wake_evt_unit`

## Requirements
- R1: After the power-up reset (`rst_n` low) has been released, the status byte and the enable byte both read 0, and `pwr_on_o`, `sci_o` and `rst_o` are all low.
- R2: A 1 on `evt_i[i]` during a clock cycle sets status bit i at the next edge, whatever enable bit i holds. The bit stays set until it is cleared.
- R3: A write to offset 0 clears every status bit whose write-data bit is 1 and leaves every bit whose write-data bit is 0 unchanged. If an event arrives for a bit in the same cycle as a clear of that bit, the bit stays set.
- R4: `bus_rdata` is a combinational read. It returns status at offset 0, enable at offset 4, and 0 at offsets 1, 2, 3, 5, 6 and 7. Writes to those other offsets change no register.
- R5: A write to offset 4 loads all eight enable bits from the write data, and the enable byte reads back at offset 4.
- R6: A `mst_clr` pulse clears enable bits 7 to 4 at the next edge. It keeps enable bits 3 to 0 and all status bits. If `mst_clr` and an enable write fall in the same cycle, bits 3 to 0 take the write data and bits 7 to 4 become 0.
- R7: `pwr_on_o` is high exactly when, for some i from 0 to 3, status bit i and enable bit i are both 1. Sources 4 to 7 never raise it.
- R8: The wake request is the OR over all eight sources of (status AND enable). When `route_rst` is 0 the request drives `sci_o` and `rst_o` stays low. When `route_rst` is 1 the request drives `rst_o` and `sci_o` stays low.
- R9: The outputs are combinational from the registers and `route_rst`. They fall in the cycle after a clear of the last contributing status bit or enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-up reset, asynchronous, active low |
| mst_clr | input | 1 | Synchronous master reset pulse, active high |
| evt_i | input | 8 | Qualified event pulses, one per source |
| bus_wr | input | 1 | Host write strobe |
| bus_addr | input | 3 | Host byte offset |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Host read data (combinational) |
| route_rst | input | 1 | 0 steers the wake request to `sci_o`, 1 steers it to `rst_o` |
| pwr_on_o | output | 1 | Power-on control request (sources 0 to 3) |
| sci_o | output | 1 | System control interrupt request |
| rst_o | output | 1 | Reset request |

## Verification
The bench clears a bit in the same cycle as an event on that bit. A design that let the clear win would lose a wake. It applies master reset together with an enable write, and checks that the lower half is kept. A design that cleared the whole byte would silently lose the lower-half enables. It sets only high-numbered sources while their enables are on, so a design that routed GPIO-class sources to the power-on output would switch the system on when it should not. It also toggles the routing bit while a request is pending, and writes to reserved offsets to catch stray decode.

// File: rtl/wkev_pkg.sv
package wkev_pkg;
  localparam int unsigned N_SRC   = 8;
  localparam int unsigned ADDR_W  = 3;
  localparam logic [ADDR_W-1:0] OFF_STS = 3'd0;
  localparam logic [ADDR_W-1:0] OFF_EN  = 3'd4;
  // sources allowed to raise the power-on control request
  localparam logic [N_SRC-1:0] PWR_MASK  = 8'h0F;
  // enable bits cleared by the master reset
  localparam logic [N_SRC-1:0] MCLR_MASK = 8'hF0;
endpackage

// File: rtl/wkev_rst_sync.sv
module wkev_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/wkev_status.sv
module wkev_status #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] sts_o
);
  logic [N-1:0] sts_q;
  logic [N-1:0] sts_d;
  logic [N-1:0] sts_ce;

  for (genvar gi = 0; gi < N; gi++) begin : g_bit
    always_comb begin
      sts_ce[gi] = evt_i[gi] | clr_i[gi];
      if (evt_i[gi])      sts_d[gi] = 1'b1;  // event beats clear
      else if (clr_i[gi]) sts_d[gi] = 1'b0;
      else                sts_d[gi] = sts_q[gi];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           sts_q[gi] <= 1'b0;
      else if (sts_ce[gi])  sts_q[gi] <= sts_d[gi];
    end
  end

  assign sts_o = sts_q;

  assert_evt_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i != '0) |=> ((sts_q & $past(evt_i)) == $past(evt_i)));

  assert_w1c_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_i & ~evt_i) != '0) |=> ((sts_q & $past(clr_i & ~evt_i)) == '0));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i == '0 && clr_i == '0) |=> $stable(sts_q));
endmodule

// File: rtl/wkev_enable.sv
module wkev_enable #(
  parameter int unsigned N = 8,
  parameter logic [N-1:0] MCLR_MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic [N-1:0] wdata_i,
  input  logic         mclr_i,
  output logic [N-1:0] en_o
);
  logic [N-1:0] en_q;
  logic [N-1:0] en_d;
  logic         en_ce;

  always_comb begin
    en_ce = wr_i | mclr_i;
    en_d  = wr_i ? wdata_i : en_q;
    if (mclr_i) en_d = en_d & ~MCLR_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_ce) en_q <= en_d;
  end

  assign en_o = en_q;

  assert_mclr_upper_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mclr_i |=> ((en_q & MCLR_MASK) == '0));

  assert_mclr_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mclr_i && !wr_i) |=> ((en_q & ~MCLR_MASK) == $past(en_q & ~MCLR_MASK)));

  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mclr_i && !wr_i) |=> $stable(en_q));
endmodule

// File: rtl/wkev_outgate.sv
module wkev_outgate #(
  parameter int unsigned N = 8,
  parameter logic [N-1:0] PWR_MASK = '1
) (
  input  logic [N-1:0] sts_i,
  input  logic [N-1:0] en_i,
  input  logic         route_rst_i,
  output logic         pwr_on_o,
  output logic         sci_o,
  output logic         rst_o
);
  logic [N-1:0] armed;
  logic         req;

  always_comb begin
    armed    = sts_i & en_i;
    req      = |armed;
    pwr_on_o = |(armed & PWR_MASK);
    sci_o    = req & ~route_rst_i;
    rst_o    = req &  route_rst_i;
  end

  always_comb begin
    assert_route_excl_R8: assert (!(sci_o && rst_o));
    assert_pwr_implies_req_R7: assert (!pwr_on_o || sci_o || rst_o);
  end
endmodule

// File: rtl/wake_evt_unit.sv
module wake_evt_unit
  import wkev_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mst_clr,
  input  logic [N_SRC-1:0]  evt_i,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [N_SRC-1:0]  bus_wdata,
  output logic [N_SRC-1:0]  bus_rdata,
  input  logic              route_rst,
  output logic              pwr_on_o,
  output logic              sci_o,
  output logic              rst_o
);
  logic             rst_ns;
  logic [N_SRC-1:0] sts;
  logic [N_SRC-1:0] en;
  logic [N_SRC-1:0] sts_clr;
  logic             en_wr;

  wkev_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_ns)
  );

  always_comb begin
    sts_clr = (bus_wr && bus_addr == OFF_STS) ? bus_wdata : '0;
    en_wr   = bus_wr && (bus_addr == OFF_EN);
  end

  wkev_status #(.N(N_SRC)) i_status (
    .clk   (clk),
    .rst_n (rst_ns),
    .evt_i (evt_i),
    .clr_i (sts_clr),
    .sts_o (sts)
  );

  wkev_enable #(.N(N_SRC), .MCLR_MASK(MCLR_MASK)) i_enable (
    .clk     (clk),
    .rst_n   (rst_ns),
    .wr_i    (en_wr),
    .wdata_i (bus_wdata),
    .mclr_i  (mst_clr),
    .en_o    (en)
  );

  wkev_outgate #(.N(N_SRC), .PWR_MASK(PWR_MASK)) i_outgate (
    .sts_i       (sts),
    .en_i        (en),
    .route_rst_i (route_rst),
    .pwr_on_o    (pwr_on_o),
    .sci_o       (sci_o),
    .rst_o       (rst_o)
  );

  always_comb begin
    case (bus_addr)
      OFF_STS: bus_rdata = sts;
      OFF_EN:  bus_rdata = en;
      default: bus_rdata = '0;
    endcase
  end

  assert_rsvd_zero_R4: assert property (@(posedge clk) disable iff (!rst_ns)
    (bus_addr != OFF_STS && bus_addr != OFF_EN) |-> (bus_rdata == '0));

  assert_rsvd_nowrite_R4: assert property (@(posedge clk) disable iff (!rst_ns)
    (bus_wr && bus_addr != OFF_STS && bus_addr != OFF_EN && !mst_clr && evt_i == '0)
      |=> ($stable(sts) && $stable(en)));
endmodule

// File: tb/test_wake_evt_unit.sv
module test_wake_evt_unit;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       mst_clr;
  logic [7:0] evt_i;
  logic       bus_wr;
  logic [2:0] bus_addr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       route_rst;
  logic       pwr_on_o, sci_o, rst_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  logic [7:0] m_sts = 8'h00;
  logic [7:0] m_en  = 8'h00;

  always #10 clk = ~clk;

  wake_evt_unit i_wake_evt_unit (
    .clk(clk), .rst_n(rst_n), .mst_clr(mst_clr), .evt_i(evt_i),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .route_rst(route_rst),
    .pwr_on_o(pwr_on_o), .sci_o(sci_o), .rst_o(rst_o)
  );

  function automatic logic [7:0] exp_rd(input logic [2:0] a);
    if (a == 3'd0) return m_sts;
    if (a == 3'd4) return m_en;
    return 8'h00;
  endfunction

  function automatic logic exp_pwr();
    return |(m_sts & m_en & 8'h0F);
  endfunction

  function automatic logic exp_req();
    return |(m_sts & m_en);
  endfunction

  task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // one bus cycle: drive away from the edge, check settled outputs, advance model
  task automatic step(input logic [7:0] ev, input logic wr, input logic [2:0] a,
                      input logic [7:0] wd, input logic mc, input logic rt, input string tag);
    @(negedge clk);
    evt_i = ev; bus_wr = wr; bus_addr = a; bus_wdata = wd; mst_clr = mc; route_rst = rt;
    #1;
    chk(tag, "R4 rdata", bus_rdata, exp_rd(a));
    chk(tag, "R7 pwr_on", {7'd0, pwr_on_o}, {7'd0, exp_pwr()});
    chk(tag, "R8 sci", {7'd0, sci_o}, {7'd0, exp_req() & ~rt});
    chk(tag, "R8 rst", {7'd0, rst_o}, {7'd0, exp_req() & rt});
    if (wr && a == 3'd4) m_en = wd;
    if (mc) m_en = m_en & 8'h0F;
    if (wr && a == 3'd0) m_sts = m_sts & ~wd;
    m_sts = m_sts | ev;
  endtask

  initial begin
    int unsigned seed_dummy;
    rst_n = 1'b0; mst_clr = 1'b0; evt_i = '0; bus_wr = 1'b0;
    bus_addr = '0; bus_wdata = '0; route_rst = 1'b0;
    seed_dummy = $urandom(32'd20240607);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1: reset state
    step(8'h00, 1'b0, 3'd0, 8'h00, 1'b0, 1'b0, "R1");
    step(8'h00, 1'b0, 3'd4, 8'h00, 1'b0, 1'b0, "R1");

    // R2: event sets status with enable off
    step(8'h20, 1'b0, 3'd0, 8'h00, 1'b0, 1'b0, "R2");
    step(8'h00, 1'b0, 3'd0, 8'h00, 1'b0, 1'b0, "R2");
    step(8'h00, 1'b0, 3'd0, 8'h00, 1'b0, 1'b0, "R2");

    // R5: load enable, GPIO13 source drives interrupt only (R7, R8)
    step(8'h00, 1'b1, 3'd4, 8'hFF, 1'b0, 1'b0, "R5");
    step(8'h00, 1'b0, 3'd4, 8'h00, 1'b0, 1'b0, "R5");
    step(8'h00, 1'b0, 3'd0, 8'h00, 1'b0, 1'b1, "R8");
    step(8'h00, 1'b0, 3'd0, 8'h00, 1'b0, 1'b0, "R8");

    // R3: clear racing event keeps bit, then clear alone, then zero write
    step(8'h20, 1'b1, 3'd0, 8'h20, 1'b0, 1'b0, "R3");
    step(8'h00, 1'b0, 3'd0, 8'h00, 1'b0, 1'b0, "R3");
    step(8'h01, 1'b1, 3'd0, 8'h20, 1'b0, 1'b0, "R3");
    step(8'h00, 1'b1, 3'd0, 8'h00, 1'b0, 1'b0, "R3");
    step(8'h00, 1'b0, 3'd0, 8'h00, 1'b0, 1'b1, "R7");

    // R4: reserved offsets read 0 and ignore writes
    for (int k = 1; k < 8; k++) begin
      if (k != 4) step(8'h00, 1'b1, 3'(k), 8'hFF, 1'b0, 1'b0, "R4");
    end
    step(8'h00, 1'b0, 3'd0, 8'h00, 1'b0, 1'b0, "R4");
    step(8'h00, 1'b0, 3'd4, 8'h00, 1'b0, 1'b0, "R4");

    // R6: master reset alone, then together with a write
    step(8'h00, 1'b0, 3'd4, 8'h00, 1'b1, 1'b0, "R6");
    step(8'h00, 1'b0, 3'd4, 8'h00, 1'b0, 1'b0, "R6");
    step(8'h00, 1'b0, 3'd0, 8'h00, 1'b0, 1'b0, "R6");
    step(8'h00, 1'b1, 3'd4, 8'hAA, 1'b1, 1'b0, "R6");
    step(8'h00, 1'b0, 3'd4, 8'h00, 1'b0, 1'b0, "R6");

    // R9: dropping enable removes the request next cycle
    step(8'h00, 1'b1, 3'd4, 8'h00, 1'b0, 1'b0, "R9");
    step(8'h00, 1'b0, 3'd0, 8'h00, 1'b0, 1'b0, "R9");
    step(8'h00, 1'b1, 3'd4, 8'h01, 1'b0, 1'b0, "R9");
    step(8'h00, 1'b1, 3'd0, 8'hFF, 1'b0, 1'b0, "R9");
    step(8'h00, 1'b0, 3'd0, 8'h00, 1'b0, 1'b0, "R9");

    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [7:0] ev;
      logic [2:0] a;
      ev = 8'($urandom & $urandom & $urandom);
      a  = ($urandom % 3 == 0) ? 3'($urandom) : (($urandom % 2 == 0) ? 3'd0 : 3'd4);
      step(ev, 1'($urandom % 3 == 0), a, 8'($urandom),
           1'($urandom % 40 == 0), 1'($urandom), "RND");
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule